// File: doc/BRIEF.md
# Streaming Top-K Ranking Memory

This block sits beside a chain of multiply units and keeps, in place, the highest scores seen so far for one query or for several queries at once. Candidate scores arrive one per handshake, each with a document index. While a list still has free slots, scores are stored in arrival order. Once it is full, the block holds a threshold equal to the smallest retained score. A score that does not beat that threshold is dropped in the accept cycle. A score that does beat it overwrites the slot that holds the minimum. A rescan of the list then finds the new minimum and loads it as the threshold. While the block is writing or scanning, the input is stalled.

A static mode input chooses between one list that uses every slot and several equal lists. In split mode each list occupies its own slot range, and a query-select input on the stream picks the list. A combinational readout port returns the score, the document index and an occupied flag for any slot. The host uses it to drain the final, unsorted lists.

The controller has three states. IDLE accepts input. REPLACE performs the one-cycle overwrite of the minimum slot. SCAN reads the active list one slot per cycle. The transitions are as follows. IDLE stays in IDLE after a fill that does not complete the list, after a rejected score, or when no input is valid. IDLE goes to SCAN when a fill completes the list. IDLE goes to REPLACE when a full list receives a score above its threshold. REPLACE always goes to SCAN. SCAN goes back to IDLE after reading the last slot of the list.

Top module: `topk_rank_mem`

## Requirements
- R1: After reset, `in_ready` is 1 and every slot reads back with `rd_used` = 0.
- R2: The first N scores accepted into a list (N = list depth) are written to consecutive slots starting at the list's base slot, in arrival order, whatever their value. The input is not stalled after any of these fills except the one that completes the list.
- R3: The accept that completes a list holds `in_ready` low for exactly N cycles, the scan that sets the threshold.
- R4: Once a list is full, a score less than or equal to its smallest retained score is discarded. `in_ready` stays high and no slot changes.
- R5: Once a list is full, a score greater than its smallest retained score, together with its document index, overwrites the slot that holds that minimum. When several slots tie for the minimum, the lowest-numbered slot is overwritten.
- R6: A replacement holds `in_ready` low for exactly N+1 cycles: one write cycle and N scan cycles.
- R7: After a replacement, the threshold is the new minimum of the list. A later score equal to it is rejected, and a later score above it replaces the slot that holds it.
- R8: With `split_mode` = 1, `in_qid` = q selects the list at slots q·(SLOTS/LANES) to q·(SLOTS/LANES)+SLOTS/LANES−1, with N = SLOTS/LANES. Each list has its own fill count and threshold.
- R9: With `split_mode` = 0, `in_qid` is ignored and a single list of N = SLOTS slots starts at slot 0. `split_mode` is only changed while `rst` is high.
- R10: `rd_score`, `rd_doc` and `rd_used` show slot `rd_slot` in the same cycle, including while a write or scan is in progress. A slot written by a replacement shows its old contents during the REPLACE cycle and the new contents from the following cycle on.
- R11: A score presented while `in_ready` is low is not consumed. It is taken, unchanged, on the first cycle in which `in_ready` is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| split_mode | input | 1 | 0: one list of SLOTS entries; 1: LANES lists of SLOTS/LANES entries |
| in_valid | input | 1 | A candidate score is presented |
| in_ready | output | 1 | Block can take a candidate this cycle |
| in_score | input | SCORE_W | Candidate score, unsigned |
| in_doc | input | DOC_W | Document index of the candidate |
| in_qid | input | $clog2(LANES) | List select in split mode |
| rd_slot | input | $clog2(SLOTS) | Slot to read out |
| rd_score | output | SCORE_W | Score held in `rd_slot` |
| rd_doc | output | DOC_W | Document index held in `rd_slot` |
| rd_used | output | 1 | `rd_slot` has been written since reset |

## Verification
The readout port and the replacement write can touch the same slot in the same cycle. The bench provokes this by parking `rd_slot` on the slot that holds the minimum before it sends a score that beats the threshold. It then samples the readout in the REPLACE cycle, where the old entry is expected, and again one cycle later, where the new entry is expected. A second overlap arises when a new score waits at the input while a scan is still running. The bench holds `in_valid` high with fresh data through a whole stall and checks that this data lands only after the scan, in the slot chosen by the rescanned threshold.

// File: rtl/topk_rank_pkg.sv
package topk_rank_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_REPLACE = 2'd1,
        ST_SCAN    = 2'd2
    } rank_state_t;
endpackage

// File: rtl/topk_entry_store.sv
module topk_entry_store #(
    parameter int SCORE_W = 16,
    parameter int DOC_W   = 12,
    parameter int SLOTS   = 8,
    parameter int AW      = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [AW-1:0]      waddr,
    input  logic [SCORE_W-1:0] wscore,
    input  logic [DOC_W-1:0]   wdoc,
    input  logic [AW-1:0]      scan_addr,
    output logic [SCORE_W-1:0] scan_score,
    input  logic [AW-1:0]      rd_addr,
    output logic [SCORE_W-1:0] rd_score,
    output logic [DOC_W-1:0]   rd_doc,
    output logic               rd_used
);
    logic [SCORE_W-1:0] score_mem [SLOTS];
    logic [DOC_W-1:0]   doc_mem   [SLOTS];
    logic [SLOTS-1:0]   used_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOTS; i++) begin
                score_mem[i] <= '0;
                doc_mem[i]   <= '0;
            end
            used_q <= '0;
        end else if (we) begin
            score_mem[waddr] <= wscore;
            doc_mem[waddr]   <= wdoc;
            used_q[waddr]    <= 1'b1;
        end
    end

    assign scan_score = score_mem[scan_addr];
    assign rd_score   = score_mem[rd_addr];
    assign rd_doc     = doc_mem[rd_addr];
    assign rd_used    = used_q[rd_addr];

    // R10: a write is visible on the next cycle
    assert_write_lands_R10: assert property (@(posedge clk) disable iff (rst)
        we |=> (score_mem[$past(waddr)] == $past(wscore)) && used_q[$past(waddr)]);
endmodule

// File: rtl/topk_min_scan.sv
module topk_min_scan #(
    parameter int SCORE_W = 16,
    parameter int AW      = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               step,
    input  logic               first,
    input  logic [SCORE_W-1:0] val,
    input  logic [AW-1:0]      addr,
    output logic [SCORE_W-1:0] min_val,
    output logic [AW-1:0]      min_addr
);
    logic [SCORE_W-1:0] run_val_q;
    logic [AW-1:0]      run_addr_q;

    // strict less-than keeps the lowest slot among equal minima
    always_comb begin
        if (first || (val < run_val_q)) begin
            min_val  = val;
            min_addr = addr;
        end else begin
            min_val  = run_val_q;
            min_addr = run_addr_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_val_q  <= '0;
            run_addr_q <= '0;
        end else if (step) begin
            run_val_q  <= min_val;
            run_addr_q <= min_addr;
        end
    end

    // R7: the running minimum never grows while a scan continues
    assert_min_monotone_R7: assert property (@(posedge clk) disable iff (rst)
        (step && !first) |-> (min_val <= run_val_q));
endmodule

// File: rtl/topk_lane_ctx.sv
module topk_lane_ctx #(
    parameter int SCORE_W = 16,
    parameter int AW      = 3,
    parameter int CW      = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               inc,
    input  logic               upd,
    input  logic [SCORE_W-1:0] new_thr,
    input  logic [AW-1:0]      new_min,
    output logic [CW-1:0]      cnt,
    output logic [SCORE_W-1:0] thr,
    output logic [AW-1:0]      min_slot
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            thr      <= '0;
            min_slot <= '0;
        end else begin
            if (inc) cnt <= cnt + CW'(1);
            if (upd) begin
                thr      <= new_thr;
                min_slot <= new_min;
            end
        end
    end

    // R3: a fill and a threshold load never coincide
    assert_fill_vs_load_R3: assert property (@(posedge clk) disable iff (rst)
        !(inc && upd));
endmodule

// File: rtl/topk_rank_mem.sv
module topk_rank_mem
    import topk_rank_pkg::*;
#(
    parameter int SCORE_W = 16,
    parameter int DOC_W   = 12,
    parameter int SLOTS   = 8,
    parameter int LANES   = 2,
    localparam int QW     = $clog2(LANES),
    localparam int AW     = $clog2(SLOTS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               split_mode,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [SCORE_W-1:0] in_score,
    input  logic [DOC_W-1:0]   in_doc,
    input  logic [QW-1:0]      in_qid,
    input  logic [AW-1:0]      rd_slot,
    output logic [SCORE_W-1:0] rd_score,
    output logic [DOC_W-1:0]   rd_doc,
    output logic               rd_used
);
    localparam int LANE_SLOTS = SLOTS / LANES;
    localparam int CW         = $clog2(SLOTS + 1);
    localparam logic [CW-1:0] FULL_DEPTH  = CW'(SLOTS);
    localparam logic [CW-1:0] SPLIT_DEPTH = CW'(LANE_SLOTS);

    rank_state_t        state_q, state_d;
    logic [QW-1:0]      act_lane_q;
    logic [SCORE_W-1:0] pend_score_q;
    logic [DOC_W-1:0]   pend_doc_q;
    logic [AW-1:0]      scan_ptr_q;

    logic [CW-1:0]      lane_cnt [LANES];
    logic [SCORE_W-1:0] lane_thr [LANES];
    logic [AW-1:0]      lane_min [LANES];

    logic [CW-1:0]      depth;
    logic [QW-1:0]      in_lane;
    logic [AW-1:0]      in_base, act_base, act_last;
    logic [CW-1:0]      cur_cnt;
    logic               is_fill, fill_last, beats;

    logic               st_we, fill_inc, scan_step, scan_first, scan_done;
    logic [AW-1:0]      st_waddr;
    logic [SCORE_W-1:0] st_wscore, scan_score, best_val;
    logic [DOC_W-1:0]   st_wdoc;
    logic [AW-1:0]      best_addr;

    assign depth     = split_mode ? SPLIT_DEPTH : FULL_DEPTH;
    assign in_lane   = split_mode ? in_qid : '0;
    assign in_base   = AW'(in_lane) * AW'(LANE_SLOTS);
    assign act_base  = AW'(act_lane_q) * AW'(LANE_SLOTS);
    assign act_last  = act_base + AW'(depth - CW'(1));
    assign cur_cnt   = lane_cnt[in_lane];
    assign is_fill   = cur_cnt < depth;
    assign fill_last = cur_cnt == (depth - CW'(1));
    assign beats     = in_score > lane_thr[in_lane];

    assign scan_first = scan_ptr_q == act_base;
    assign scan_done  = (state_q == ST_SCAN) && (scan_ptr_q == act_last);

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid) begin
                    if (is_fill) begin
                        if (fill_last) state_d = ST_SCAN;
                    end else if (beats) begin
                        state_d = ST_REPLACE;
                    end
                end
            end
            ST_REPLACE: state_d = ST_SCAN;
            ST_SCAN:    if (scan_ptr_q == act_last) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs and datapath controls
    always_comb begin
        in_ready  = 1'b0;
        st_we     = 1'b0;
        st_waddr  = '0;
        st_wscore = '0;
        st_wdoc   = '0;
        fill_inc  = 1'b0;
        scan_step = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = 1'b1;
                if (in_valid && is_fill) begin
                    st_we     = 1'b1;
                    st_waddr  = in_base + AW'(cur_cnt);
                    st_wscore = in_score;
                    st_wdoc   = in_doc;
                    fill_inc  = 1'b1;
                end
            end
            ST_REPLACE: begin
                st_we     = 1'b1;
                st_waddr  = lane_min[act_lane_q];
                st_wscore = pend_score_q;
                st_wdoc   = pend_doc_q;
            end
            ST_SCAN: scan_step = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_lane_q   <= '0;
            pend_score_q <= '0;
            pend_doc_q   <= '0;
            scan_ptr_q   <= '0;
        end else if (state_q == ST_IDLE && in_valid) begin
            act_lane_q   <= in_lane;
            pend_score_q <= in_score;
            pend_doc_q   <= in_doc;
            scan_ptr_q   <= in_base;
        end else if (state_q == ST_SCAN) begin
            scan_ptr_q   <= scan_ptr_q + AW'(1);
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        topk_lane_ctx #(.SCORE_W(SCORE_W), .AW(AW), .CW(CW)) u_ctx (
            .clk      (clk),
            .rst      (rst),
            .inc      (fill_inc && (in_lane == QW'(l))),
            .upd      (scan_done && (act_lane_q == QW'(l))),
            .new_thr  (best_val),
            .new_min  (best_addr),
            .cnt      (lane_cnt[l]),
            .thr      (lane_thr[l]),
            .min_slot (lane_min[l])
        );
    end

    topk_min_scan #(.SCORE_W(SCORE_W), .AW(AW)) u_scan (
        .clk      (clk),
        .rst      (rst),
        .step     (scan_step),
        .first    (scan_first),
        .val      (scan_score),
        .addr     (scan_ptr_q),
        .min_val  (best_val),
        .min_addr (best_addr)
    );

    topk_entry_store #(.SCORE_W(SCORE_W), .DOC_W(DOC_W), .SLOTS(SLOTS), .AW(AW)) u_store (
        .clk        (clk),
        .rst        (rst),
        .we         (st_we),
        .waddr      (st_waddr),
        .wscore     (st_wscore),
        .wdoc       (st_wdoc),
        .scan_addr  (scan_ptr_q),
        .scan_score (scan_score),
        .rd_addr    (rd_slot),
        .rd_score   (rd_score),
        .rd_doc     (rd_doc),
        .rd_used    (rd_used)
    );

    // stall length watch for the assertions below
    logic [CW:0] stall_run_q;
    always_ff @(posedge clk) begin
        if (rst || in_ready) stall_run_q <= '0;
        else                 stall_run_q <= stall_run_q + 1'b1;
    end

    assert_fill_no_stall_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && is_fill && !fill_last) |=> in_ready);

    assert_reject_no_stall_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !is_fill && !beats) |=> in_ready);

    assert_replace_beats_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_REPLACE) |-> (pend_score_q > lane_thr[act_lane_q]));

    assert_stall_bound_R6: assert property (@(posedge clk) disable iff (rst)
        stall_run_q <= (CW+1)'(SLOTS + 1));

    assert_write_in_lane_R8: assert property (@(posedge clk) disable iff (rst)
        st_we |-> ((st_waddr >= ((state_q == ST_IDLE) ? in_base : act_base)) &&
                   ({1'b0, st_waddr} < ({1'b0, ((state_q == ST_IDLE) ? in_base : act_base)} + (AW+1)'(depth)))));

    assert_mode_static_R9: assert property (@(posedge clk) disable iff (rst)
        $stable(split_mode));
endmodule

// File: tb/topk_rank_mem_test.sv
module topk_rank_mem_test;
    localparam int CLK_PERIOD = 10;
    localparam int SW = 16;
    localparam int DW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          split_mode = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [SW-1:0] in_score = '0;
    logic [DW-1:0] in_doc = '0;
    logic [0:0]    in_qid = '0;
    logic [2:0]    rd_slot = '0;
    logic [SW-1:0] rd_score;
    logic [DW-1:0] rd_doc;
    logic          rd_used;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    topk_rank_mem #(.SCORE_W(SW), .DOC_W(DW), .SLOTS(8), .LANES(2)) uut (
        .clk(clk), .rst(rst), .split_mode(split_mode),
        .in_valid(in_valid), .in_ready(in_ready), .in_score(in_score),
        .in_doc(in_doc), .in_qid(in_qid), .rd_slot(rd_slot),
        .rd_score(rd_score), .rd_doc(rd_doc), .rd_used(rd_used)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_slot(input int slot, input int sc, input int dc, input string req);
        rd_slot = slot[2:0];
        #1;
        check(req, $sformatf("slot%0d used", slot), int'(rd_used), 1);
        check(req, $sformatf("slot%0d score", slot), int'(rd_score), sc);
        check(req, $sformatf("slot%0d doc", slot), int'(rd_doc), dc);
    endtask

    // called at a falling edge; returns at a falling edge with in_ready high
    task automatic send(input int s, input int d, input int q, output int stall);
        in_valid = 1'b1; in_score = s[SW-1:0]; in_doc = d[DW-1:0]; in_qid = q[0:0];
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        stall = 0;
        while (!in_ready) begin stall++; @(negedge clk); end
    endtask

    task automatic apply_reset(input bit mode);
        @(negedge clk);
        rst = 1'b1; split_mode = mode; in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic test_reset();
        apply_reset(1'b0);
        check("R1", "ready after reset", int'(in_ready), 1);
        for (int i = 0; i < 8; i++) begin
            rd_slot = i[2:0]; #1;
            check("R1", $sformatf("slot%0d used after reset", i), int'(rd_used), 0);
        end
    endtask

    task automatic test_fill_single();
        int vals [8] = '{50, 20, 70, 20, 90, 30, 60, 40};
        int st;
        for (int i = 0; i < 8; i++) begin
            send(vals[i], i + 1, i % 2, st);   // R9: qid alternates but is ignored
            check(i == 7 ? "R3" : "R2", $sformatf("stall after fill %0d", i), st, i == 7 ? 8 : 0);
        end
        for (int i = 0; i < 8; i++) check_slot(i, vals[i], i + 1, "R2");
    endtask

    task automatic test_filter_ties();
        int st;
        send(20, 100, 0, st);
        check("R4", "stall on tie", st, 0);
        check_slot(1, 20, 2, "R4");
        check_slot(3, 20, 4, "R4");
        send(10, 101, 1, st);
        check("R4", "stall on low score", st, 0);
        for (int i = 0; i < 8; i++) begin
            rd_slot = i[2:0]; #1;
            check("R4", "no doc 101 stored", int'(rd_doc == 101), 0);
        end
    endtask

    task automatic test_replace_observe();
        int st;
        rd_slot = 3'd1;
        in_valid = 1'b1; in_score = 16'd25; in_doc = 12'd9; in_qid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check("R6", "ready in write cycle", int'(in_ready), 0);
        check("R10", "old score during write", int'(rd_score), 20);
        check("R10", "old doc during write", int'(rd_doc), 2);
        st = 1;
        @(negedge clk);
        check("R5", "lowest tied minimum slot replaced score", int'(rd_score), 25);
        check("R5", "lowest tied minimum slot replaced doc", int'(rd_doc), 9);
        while (!in_ready) begin st++; @(negedge clk); end
        check("R6", "replacement stall", st, 9);
        check_slot(3, 20, 4, "R5");
    endtask

    task automatic test_rescan_threshold();
        int st;
        send(21, 10, 0, st);
        check("R7", "stall replacing new minimum", st, 9);
        check_slot(3, 21, 10, "R7");
        send(21, 11, 0, st);
        check("R7", "stall on tie with new threshold", st, 0);
        check_slot(3, 21, 10, "R7");
    endtask

    task automatic test_held_input();
        int st1, st2;
        in_valid = 1'b1; in_score = 16'd23; in_doc = 12'd11; in_qid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        in_score = 16'd24; in_doc = 12'd12;   // R11: held through the stall
        st1 = 0;
        while (!in_ready) begin st1++; @(negedge clk); end
        check("R11", "stall of first replacement", st1, 9);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        st2 = 0;
        while (!in_ready) begin st2++; @(negedge clk); end
        check("R11", "held score taken after stall", st2, 9);
        check_slot(3, 24, 12, "R11");
        check_slot(1, 25, 9, "R11");
        send(24, 13, 0, st1);
        check("R7", "tie rejected", st1, 0);
        send(26, 14, 0, st1);
        check_slot(3, 26, 14, "R7");
    endtask

    task automatic test_split();
        int st;
        apply_reset(1'b1);
        for (int i = 0; i < 4; i++) begin
            send(5 + i, 1 + i, 0, st);
            check(i == 3 ? "R3" : "R8", $sformatf("lane0 fill %0d stall", i), st, i == 3 ? 4 : 0);
            send(100 * (i + 1), 11 + i, 1, st);
            check(i == 3 ? "R3" : "R8", $sformatf("lane1 fill %0d stall", i), st, i == 3 ? 4 : 0);
        end
        check_slot(3, 8, 4, "R8");
        check_slot(4, 100, 11, "R8");
        check_slot(7, 400, 14, "R8");
        send(50, 20, 1, st);
        check("R8", "lane1 rejects below own threshold", st, 0);
        check_slot(4, 100, 11, "R8");
        send(50, 21, 0, st);
        check("R8", "lane0 replacement stall", st, 5);
        check_slot(0, 50, 21, "R8");
        send(150, 22, 1, st);
        check("R8", "lane1 replacement stall", st, 5);
        check_slot(4, 150, 22, "R8");
        check_slot(1, 6, 2, "R8");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_fill_single();
        test_filter_ties();
        test_replace_observe();
        test_rescan_threshold();
        test_held_input();
        test_split();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule